// File: doc/BRIEF.md
# LIN Master Timeout Supervisor

This block watches the timing of a LIN frame on the master side. An 8-bit counter advances once per bit time. When timeout supervision is switched on, the start of the Synch Field makes the block load two compare values from the current counter value. The first compare value guards the header and then the response. The second guards the whole frame. When the counter reaches a compare value while supervision is armed, a sticky timeout flag is raised and supervision stops.

The surrounding protocol engine provides a one-cycle pulse for each of these events: a bit time elapsed, the break delimiter ended and the Synch Field began, the header completed, and the frame completed. Software reads both compare values at all times. It may write them only while supervision mode is off.

A data length above eight bytes cannot be supervised. In that case a configuration error is shown and no compare value is loaded. A clock-gating request is granted only while no frame is in progress.

Top module: `lin_tmo_ctrl`

## Requirements
- R1: `bit_cnt_o` is 0 after reset. It increases by one, wrapping from 255 to 0, in the cycle after each cycle in which `bit_tick` is high, and holds otherwise.
- R2: While `tmo_mode_en` is low, `sw_oc_we[0]` writes `sw_oc_wdata` to the first compare value and `sw_oc_we[1]` writes it to the second, visible one cycle later. While `tmo_mode_en` is high these writes have no effect.
- R3: An arm event is a cycle with `brk_to_sync` high, `tmo_mode_en` high and no configuration error. On an arm event, with C the counter value in that cycle, the next cycle shows `oc1_o` = (C+28) mod 256 and `oc2_o` = (C+28+9·`rto_tune`) mod 256. It also sets `tmo_active_o`, enters the header phase and clears all three timeout flags.
- R4: A `hdr_done` pulse while armed in the header phase, in a cycle with no timeout and no `frm_done`, reloads `oc1_o` with (C+9·`rto_tune`) mod 256 and enters the response phase.
- R5: While armed in the header phase, a cycle where the counter equals `oc1_o` sets `hdr_tmo_o` and clears `tmo_active_o` on the next edge.
- R6: While armed in the response phase, a cycle where the counter equals `oc1_o` sets `rsp_tmo_o` and clears `tmo_active_o`.
- R7: While armed in either phase, a cycle where the counter equals `oc2_o` sets `frm_tmo_o` and clears `tmo_active_o`. This can happen in the same cycle as R5 or R6.
- R8: `frm_done` clears `tmo_active_o`. The timeout flags stay set until the next arm event.
- R9: `cfg_err_o` is high, combinationally, exactly when `tmo_mode_en` is high and `data_len` is greater than 8. While it is high, `brk_to_sync` does not arm and loads nothing.
- R10: A frame is in progress from a `brk_to_sync` pulse, in any mode, until a `frm_done` pulse. `gate_ack_o` is high in the cycle after a cycle where `gate_req` is high and the updated in-progress state is clear.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_mode_en | input | 1 | Timeout supervision mode |
| rto_tune | input | 4 | Response factor, scaled by 9 bit times |
| data_len | input | 4 | Configured data field length in bytes |
| bit_tick | input | 1 | One pulse per bit time |
| brk_to_sync | input | 1 | Break delimiter ended, Synch Field starts |
| hdr_done | input | 1 | Header completed |
| frm_done | input | 1 | Frame transmission or reception completed |
| sw_oc_we | input | 2 | Software write strobes for compare 1 and 2 |
| sw_oc_wdata | input | 8 | Software write data |
| gate_req | input | 1 | Clock-gating request |
| bit_cnt_o | output | 8 | Free-running bit counter |
| oc1_o | output | 8 | Header/response compare value |
| oc2_o | output | 8 | Frame compare value |
| tmo_active_o | output | 1 | Supervision armed |
| hdr_tmo_o | output | 1 | Sticky header timeout |
| rsp_tmo_o | output | 1 | Sticky response timeout |
| frm_tmo_o | output | 1 | Sticky frame timeout |
| cfg_err_o | output | 1 | Unsupported length with mode on |
| gate_ack_o | output | 1 | Clock-gating acknowledge |

## Verification
The frame timeout is the hardest event to reach. The second compare value always lies at or beyond the point where the header or response check fires, so the frame flag cannot be raised first through hardware loads alone. The stimulus reaches it in two directed ways. One uses a zero response factor, which makes both compares equal so that the header and frame flags rise in the same cycle. The other switches the mode off while armed and writes a near compare value through software. Long tick runs carry the counter across the wrap before arming, which exercises the modulo-256 loads.

// File: rtl/lin_tmo_pkg.sv
package lin_tmo_pkg;
    typedef enum logic {
        PH_HDR = 1'b0,
        PH_RSP = 1'b1
    } tmo_phase_e;
endpackage

// File: rtl/lin_tmo_counter.sv
module lin_tmo_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/lin_tmo_engine.sv
module lin_tmo_engine
    import lin_tmo_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RTO_W    = 4,
    parameter int HDR_BITS = 28,
    parameter int RSP_MUL  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [RTO_W-1:0] rto_i,
    input  logic             load_i,
    input  logic             hdr_done_i,
    input  logic             frm_done_i,
    input  logic             sw_open_i,
    input  logic [1:0]       sw_we_i,
    input  logic [CNT_W-1:0] sw_data_i,
    output logic [CNT_W-1:0] oc1_o,
    output logic [CNT_W-1:0] oc2_o,
    output logic             active_o,
    output logic             hdr_tmo_o,
    output logic             rsp_tmo_o,
    output logic             frm_tmo_o
);
    localparam logic [CNT_W-1:0] HDR_SPAN = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] MUL_K    = CNT_W'(RSP_MUL);

    typedef struct packed {
        logic [CNT_W-1:0] oc1;
        logic [CNT_W-1:0] oc2;
        logic             active;
        tmo_phase_e       phase;
        logic             hdr_tmo;
        logic             rsp_tmo;
        logic             frm_tmo;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [CNT_W-1:0] rsp_span;
    logic             hit_hdr, hit_rsp, hit_frm, stop;

    always_comb begin
        rsp_span = CNT_W'(CNT_W'(rto_i) * MUL_K);
        hit_hdr  = st_q.active && (st_q.phase == PH_HDR) && (cnt_i == st_q.oc1);
        hit_rsp  = st_q.active && (st_q.phase == PH_RSP) && (cnt_i == st_q.oc1);
        hit_frm  = st_q.active && (cnt_i == st_q.oc2);
        stop     = hit_hdr || hit_rsp || hit_frm || frm_done_i;

        st_d = st_q;
        if (hit_hdr) st_d.hdr_tmo = 1'b1;
        if (hit_rsp) st_d.rsp_tmo = 1'b1;
        if (hit_frm) st_d.frm_tmo = 1'b1;
        if (stop)    st_d.active  = 1'b0;

        if (hdr_done_i && st_q.active && (st_q.phase == PH_HDR) && !stop) begin
            st_d.oc1   = cnt_i + rsp_span;
            st_d.phase = PH_RSP;
        end

        if (sw_open_i) begin
            if (sw_we_i[0]) st_d.oc1 = sw_data_i;
            if (sw_we_i[1]) st_d.oc2 = sw_data_i;
        end

        if (load_i) begin
            st_d.oc1     = cnt_i + HDR_SPAN;
            st_d.oc2     = cnt_i + HDR_SPAN + rsp_span;
            st_d.active  = 1'b1;
            st_d.phase   = PH_HDR;
            st_d.hdr_tmo = 1'b0;
            st_d.rsp_tmo = 1'b0;
            st_d.frm_tmo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc1_o     = st_q.oc1;
    assign oc2_o     = st_q.oc2;
    assign active_o  = st_q.active;
    assign hdr_tmo_o = st_q.hdr_tmo;
    assign rsp_tmo_o = st_q.rsp_tmo;
    assign frm_tmo_o = st_q.frm_tmo;

    assert_arm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (oc1_o == $past(cnt_i) + HDR_SPAN) && active_o && !hdr_tmo_o);
    assert_oc2_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_open_i && !load_i) |=> $stable(oc2_o));
    assert_frame_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && (cnt_i == oc2_o) && !load_i) |=> (frm_tmo_o && !active_o));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_tmo_o && !load_i) |=> hdr_tmo_o);
    assert_done_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done_i && !load_i) |=> !active_o);
endmodule

// File: rtl/lin_tmo_ctrl.sv
module lin_tmo_ctrl #(
    parameter int CNT_W    = 8,
    parameter int RTO_W    = 4,
    parameter int LEN_W    = 4,
    parameter int MAX_LEN  = 8,
    parameter int HDR_BITS = 28,
    parameter int RSP_MUL  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_mode_en,
    input  logic [RTO_W-1:0] rto_tune,
    input  logic [LEN_W-1:0] data_len,
    input  logic             bit_tick,
    input  logic             brk_to_sync,
    input  logic             hdr_done,
    input  logic             frm_done,
    input  logic [1:0]       sw_oc_we,
    input  logic [CNT_W-1:0] sw_oc_wdata,
    input  logic             gate_req,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [CNT_W-1:0] oc1_o,
    output logic [CNT_W-1:0] oc2_o,
    output logic             tmo_active_o,
    output logic             hdr_tmo_o,
    output logic             rsp_tmo_o,
    output logic             frm_tmo_o,
    output logic             cfg_err_o,
    output logic             gate_ack_o
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    typedef struct packed {
        logic in_frame;
        logic gate_ack;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    arm;

    always_comb begin
        cfg_err_o = tmo_mode_en && (data_len > LEN_LIMIT);
        arm       = brk_to_sync && tmo_mode_en && !cfg_err_o;

        st_d = st_q;
        if (brk_to_sync)   st_d.in_frame = 1'b1;
        else if (frm_done) st_d.in_frame = 1'b0;
        st_d.gate_ack = gate_req && !st_d.in_frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_ack_o = st_q.gate_ack;

    lin_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (bit_tick),
        .cnt_o  (bit_cnt_o)
    );

    lin_tmo_engine #(
        .CNT_W    (CNT_W),
        .RTO_W    (RTO_W),
        .HDR_BITS (HDR_BITS),
        .RSP_MUL  (RSP_MUL)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (bit_cnt_o),
        .rto_i      (rto_tune),
        .load_i     (arm),
        .hdr_done_i (hdr_done),
        .frm_done_i (frm_done),
        .sw_open_i  (!tmo_mode_en),
        .sw_we_i    (sw_oc_we),
        .sw_data_i  (sw_oc_wdata),
        .oc1_o      (oc1_o),
        .oc2_o      (oc2_o),
        .active_o   (tmo_active_o),
        .hdr_tmo_o  (hdr_tmo_o),
        .rsp_tmo_o  (rsp_tmo_o),
        .frm_tmo_o  (frm_tmo_o)
    );

    assert_err_blocks_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && brk_to_sync && !tmo_active_o) |=> !tmo_active_o);
    assert_no_ack_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_frame && !frm_done) |=> !gate_ack_o);
    assert_flag_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_tmo_o) |-> $past(tmo_active_o));
endmodule

// File: tb/lin_tmo_ctrl_tb.sv
module lin_tmo_ctrl_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       mode = 1'b0, tick = 1'b0, brk = 1'b0, hdn = 1'b0, fdn = 1'b0, greq = 1'b0;
    logic [3:0] rto = '0, len = '0;
    logic [1:0] we = '0;
    logic [7:0] wd = '0;
    logic [7:0] cnt, oc1, oc2;
    logic act, ht, rt, ft, err, ack;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] m_cnt, m_oc1, m_oc2;
    logic m_act, m_ph, m_h, m_r, m_f, m_inf, m_ack;

    always #(CLK_P/2) clk = ~clk;

    lin_tmo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_mode_en(mode), .rto_tune(rto), .data_len(len),
        .bit_tick(tick), .brk_to_sync(brk), .hdr_done(hdn), .frm_done(fdn),
        .sw_oc_we(we), .sw_oc_wdata(wd), .gate_req(greq),
        .bit_cnt_o(cnt), .oc1_o(oc1), .oc2_o(oc2), .tmo_active_o(act),
        .hdr_tmo_o(ht), .rsp_tmo_o(rt), .frm_tmo_o(ft), .cfg_err_o(err), .gate_ack_o(ack)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
        end
    endtask

    function automatic logic [7:0] span9(input logic [3:0] r);
        return 8'(8'(r) * 8'd9);
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_oc1 = 0; m_oc2 = 0; m_act = 0; m_ph = 0;
        m_h = 0; m_r = 0; m_f = 0; m_inf = 0; m_ack = 0;
    endtask

    task automatic model_upd();
        logic hh, rh, fh, stp, ld, e;
        logic [7:0] n_cnt, n_oc1, n_oc2;
        logic n_act, n_ph, n_h, n_r, n_f, n_inf;
        e  = mode && (len > 4'd8);
        ld = brk && mode && !e;
        hh = m_act && !m_ph && (m_cnt == m_oc1);
        rh = m_act &&  m_ph && (m_cnt == m_oc1);
        fh = m_act && (m_cnt == m_oc2);
        stp = hh || rh || fh || fdn;
        n_cnt = tick ? 8'(m_cnt + 8'd1) : m_cnt;
        n_oc1 = m_oc1; n_oc2 = m_oc2; n_act = m_act; n_ph = m_ph;
        n_h = m_h || hh; n_r = m_r || rh; n_f = m_f || fh;
        if (stp) n_act = 0;
        if (hdn && m_act && !m_ph && !stp) begin n_oc1 = 8'(m_cnt + span9(rto)); n_ph = 1; end
        if (!mode) begin
            if (we[0]) n_oc1 = wd;
            if (we[1]) n_oc2 = wd;
        end
        if (ld) begin
            n_oc1 = 8'(m_cnt + 8'd28);
            n_oc2 = 8'(m_cnt + 8'd28 + span9(rto));
            n_act = 1; n_ph = 0; n_h = 0; n_r = 0; n_f = 0;
        end
        n_inf = brk ? 1'b1 : (fdn ? 1'b0 : m_inf);
        m_ack = greq && !n_inf;
        m_cnt = n_cnt; m_oc1 = n_oc1; m_oc2 = n_oc2; m_act = n_act; m_ph = n_ph;
        m_h = n_h; m_r = n_r; m_f = n_f; m_inf = n_inf;
    endtask

    task automatic compare_all();
        chk("R1 cnt", cnt, m_cnt);
        chk("R3 oc1", oc1, m_oc1);
        chk("R3 oc2", oc2, m_oc2);
        chk("R8 active", act, m_act);
        chk("R5 hdr_tmo", ht, m_h);
        chk("R6 rsp_tmo", rt, m_r);
        chk("R7 frm_tmo", ft, m_f);
        chk("R9 cfg_err", err, int'(mode && (len > 4'd8)));
        chk("R10 gate_ack", ack, m_ack);
    endtask

    task automatic step();
        @(posedge clk);
        model_upd();
        @(negedge clk);
        compare_all();
        tick = 0; brk = 0; hdn = 0; fdn = 0; we = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; step(); end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] c0;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset cnt", cnt, 0); chk("R11 reset oc1", oc1, 0);
        chk("R11 reset act", act, 0); chk("R11 reset ack", ack, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: writes accepted when mode off
        wd = 8'h55; we = 2'b01; step();
        wd = 8'hAA; we = 2'b10; step();
        chk("R2 sw oc1", oc1, 8'h55); chk("R2 sw oc2", oc2, 8'hAA);
        // R2: ignored when mode on
        mode = 1; wd = 8'h11; we = 2'b11; step();
        chk("R2 locked oc1", oc1, 8'h55); chk("R2 locked oc2", oc2, 8'hAA);

        // R3 + R5: arm then header timeout
        ticks(10);
        c0 = cnt; rto = 4'd2; brk = 1; step();
        chk("R3 arm oc1", oc1, 8'(c0 + 8'd28));
        chk("R3 arm oc2", oc2, 8'(c0 + 8'd46));
        ticks(30);
        chk("R5 header timeout", ht, 1); chk("R5 active cleared", act, 0);

        // R4 + R6: header done then response timeout
        brk = 1; step();
        ticks(5);
        c0 = cnt; hdn = 1; step();
        chk("R4 reload oc1", oc1, 8'(c0 + 8'd18));
        ticks(20);
        chk("R6 response timeout", rt, 1); chk("R8 hdr flag cleared by arm", ht, 0);

        // R7: zero factor, header and frame coincide
        rto = 0; brk = 1; step();
        ticks(30);
        chk("R7 frame timeout", ft, 1); chk("R5 with frame", ht, 1);

        // R7: mode off mid-frame, near compare written by software
        rto = 4'd5; brk = 1; step();
        mode = 0; wd = 8'(cnt + 8'd3); we = 2'b10; step();
        ticks(4);
        chk("R7 frame timeout via sw", ft, 1);
        mode = 1;

        // R8: frame done clears active, flags stay
        brk = 1; step(); ticks(3);
        fdn = 1; step();
        chk("R8 done clears", act, 0);
        ticks(40);
        chk("R8 no flag after done", ht, 0);

        // R9: length above 8 blocks arming
        len = 4'd9; step();
        chk("R9 err", err, 1);
        brk = 1; step();
        chk("R9 no arm", act, 0);
        fdn = 1; len = 4'd8; step();
        chk("R9 err at 8", err, 0);

        // R10: gate ack only outside frame
        greq = 1; brk = 1; step();
        chk("R10 no ack in frame", ack, 0);
        ticks(3);
        fdn = 1; step();
        chk("R10 ack after done", ack, 1);
        greq = 0;

        // R1: wrap and modulo arming
        ticks(240);
        rto = 4'd15; c0 = cnt; brk = 1; step();
        chk("R3 wrap oc2", oc2, 8'(c0 + 8'd163));
        ticks(300);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            tick = $urandom_range(0, 1);
            mode = ($urandom_range(0, 9) != 0);
            len  = ($urandom_range(0, 9) == 0) ? 4'(9 + $urandom_range(0, 6)) : 4'($urandom_range(0, 8));
            brk  = ($urandom_range(0, 39) == 0);
            hdn  = ($urandom_range(0, 24) == 0);
            fdn  = ($urandom_range(0, 59) == 0);
            we   = 2'($urandom_range(0, 3));
            wd   = 8'($urandom_range(0, 255));
            rto  = 4'($urandom_range(0, 15));
            greq = ($urandom_range(0, 3) == 0);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule